// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two N-bit operands over N clock cycles using one (N+1)-bit adder/subtractor. When the block is idle, a start request loads the multiplicand into a holding register. It clears the upper half of a 2N-bit accumulator and places the multiplier in the lower half. On each following cycle, the lowest bit of the lower half decides whether the multiplicand is added to the upper half. The whole accumulator then moves right by one place. The multiplier bits are consumed from the bottom while the product bits fill in from the top.

A mode input, sampled with the operands, selects unsigned or two's-complement arithmetic. In signed mode, the multiplier's top bit carries negative weight, so the final step subtracts instead of adds. The upper half is also sign-extended on every shift. In unsigned mode, the adder's carry-out enters the top of the upper half. The finished 2N-bit product stays on the output until the next accepted start.

Top module: `shmul_core`

## Requirements
- R1: While reset is asserted, and on its release, busy_o and done_o are 0 and product_o is all zeros.
- R2: When start_i is 1 on a clock edge with busy_o at 0, the operands and the mode are captured, and busy_o is 1 after that edge.
- R3: done_o rises exactly N clock edges after the edge that accepted start, stays high for exactly one cycle, and is never high together with busy_o.
- R4: With signed_i at 0 when start is accepted, the product_o shown while done_o is 1 equals the unsigned product of the two operands, all 2N bits.
- R5: With signed_i at 1 when start is accepted, product_o equals the two's-complement product of the operands. This includes the most negative value multiplied by itself, whose product 2^(2N-2) is positive.
- R6: start_i, mult_a_i, mult_b_i and signed_i are ignored while busy_o is 1. Changing them during an operation does not alter its result or its length.
- R7: busy_o stays 1 for exactly N consecutive cycles per accepted start.
- R8: While idle with start_i at 0, product_o holds its last value whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new multiplication (taken only when idle) |
| mult_a_i | input | N | Multiplicand |
| mult_b_i | input | N | Multiplier |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| product_o | output | 2N | Accumulator; the final product is valid while done_o is 1 and afterwards while idle |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with N = 4, which makes the operand space small enough to cover completely. It runs all 256 operand pairs in each mode, so every carry-out case and every sign combination is reached. This includes the most negative value times itself and times +7. A further sequence holds start high with changed operands and a flipped mode during an operation, and then changes operands while the block is idle. This exercises the rules for ignoring inputs and for holding the result.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } shmul_mode_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } shmul_step_e;

endpackage

// File: rtl/shmul_ctrl.sv
module shmul_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_step;

  assign last_step = busy_q && (cnt_q == LAST_CNT);

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (last_step) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;
  assign last_o = last_step;
  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/shmul_addsub.sv
module shmul_addsub
  import shmul_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opd_i,
  input  shmul_step_e  op_i,
  output logic [W-1:0] sum_o
);
  logic         sub;
  logic [W-1:0] gated;
  logic [W-1:0] inv;

  always_comb begin
    sub   = (op_i == STEP_SUB);
    gated = (op_i == STEP_HOLD) ? '0 : opd_i;
    inv   = gated ^ {W{sub}};
    sum_o = acc_i + inv + W'(sub);
  end

endmodule

// File: rtl/shmul_dpath.sv
module shmul_dpath
  import shmul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           last_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  input  shmul_mode_e    mode_i,
  output logic [2*N-1:0] product_o
);
  localparam int W = N + 1;

  logic [N-1:0] mcand_q, mcand_d;
  logic [N-1:0] hi_q, hi_d;
  logic [N-1:0] lo_q, lo_d;
  shmul_mode_e  mode_q, mode_d;
  logic         en;

  logic [W-1:0] hi_ext, mcand_ext, sum;
  shmul_step_e  op;

  always_comb begin
    if (mode_q == MODE_SIGNED) begin
      hi_ext    = {hi_q[N-1], hi_q};
      mcand_ext = {mcand_q[N-1], mcand_q};
    end else begin
      hi_ext    = {1'b0, hi_q};
      mcand_ext = {1'b0, mcand_q};
    end
    if (!lo_q[0])                               op = STEP_HOLD;
    else if (last_i && mode_q == MODE_SIGNED)   op = STEP_SUB;
    else                                        op = STEP_ADD;
  end

  shmul_addsub #(.W(W)) u_addsub (
    .acc_i (hi_ext),
    .opd_i (mcand_ext),
    .op_i  (op),
    .sum_o (sum)
  );

  assign en = load_i || step_i;

  always_comb begin
    mcand_d = mcand_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    mode_d  = mode_q;
    if (load_i) begin
      mcand_d = a_i;
      hi_d    = '0;
      lo_d    = b_i;
      mode_d  = mode_i;
    end else if (step_i) begin
      hi_d = sum[W-1:1];
      lo_d = {sum[0], lo_q[N-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      mode_q  <= MODE_UNSIGNED;
    end else if (en) begin
      mcand_q <= mcand_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      mode_q  <= mode_d;
    end
  end

  assign product_o = {hi_q, lo_q};

endmodule

// File: rtl/shmul_core.sv
module shmul_core
  import shmul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [N-1:0]   mult_a_i,
  input  logic [N-1:0]   mult_b_i,
  input  logic           signed_i,
  output logic [2*N-1:0] product_o,
  output logic           busy_o,
  output logic           done_o
);
  logic load, step, last;

  shmul_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  shmul_dpath #(.N(N)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .step_i    (step),
    .last_i    (last),
    .a_i       (mult_a_i),
    .b_i       (mult_b_i),
    .mode_i    (shmul_mode_e'(signed_i)),
    .product_o (product_o)
  );

endmodule

// File: rtl/shmul_chk.sv
module shmul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [N-1:0]   mult_a_i,
  input logic [N-1:0]   mult_b_i,
  input logic           signed_i,
  input logic [2*N-1:0] product_o,
  input logic           busy_o,
  input logic           done_o
);
  localparam int BW = $clog2(N + 1) + 1;

  logic [N-1:0]   ea, eb;
  logic           em;
  logic [BW-1:0]  bcnt;
  logic [2*N-1:0] xa, xb, expect_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea   <= '0;
      eb   <= '0;
      em   <= 1'b0;
      bcnt <= '0;
    end else if (start_i && !busy_o) begin
      ea   <= mult_a_i;
      eb   <= mult_b_i;
      em   <= signed_i;
      bcnt <= '0;
    end else if (busy_o) begin
      bcnt <= bcnt + 1'b1;
    end
  end

  always_comb begin
    xa = em ? {{N{ea[N-1]}}, ea} : {{N{1'b0}}, ea};
    xb = em ? {{N{eb[N-1]}}, eb} : {{N{1'b0}}, eb};
    expect_prod = xa * xb;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (!busy_o && !done_o && product_o == '0)); // R1
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !(done_o && busy_o)); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $past(busy_o)); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (bcnt == BW'(N))); // R7
  AST_UNSIGNED_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !em) |-> (product_o == expect_prod)); // R4
  AST_SIGNED_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n) (done_o && em) |-> (product_o == expect_prod)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && !start_i) |=> $stable(product_o)); // R8

endmodule

bind shmul_core shmul_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .mult_a_i  (mult_a_i),
  .mult_b_i  (mult_b_i),
  .signed_i  (signed_i),
  .product_o (product_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/shmul_core_tb_top.sv
module shmul_core_tb_top;
  localparam int N = 4;

  logic           clk;
  logic           rst_n;
  logic           start_i;
  logic [N-1:0]   mult_a_i;
  logic [N-1:0]   mult_b_i;
  logic           signed_i;
  logic [2*N-1:0] product_o;
  logic           busy_o;
  logic           done_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit running = 0;
  bit ign_seen = 0;

  // reference model state
  bit             m_busy = 0;
  bit             m_done = 0;
  int             m_rem = 0;
  logic [2*N-1:0] m_prod = '0;
  logic [N-1:0]   m_a = '0, m_b = '0;
  bit             m_sgn = 0;
  bit             m_last_sgn = 0;

  shmul_core #(.N(N)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mult_a_i  (mult_a_i),
    .mult_b_i  (mult_b_i),
    .signed_i  (signed_i),
    .product_o (product_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [2*N-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b, bit s);
    int sa, sb, p;
    sa = int'(a);
    sb = int'(b);
    if (s && a[N-1]) sa = sa - (1 << N);
    if (s && b[N-1]) sb = sb - (1 << N);
    p = sa * sb;
    return (2*N)'(p);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rem = 0; m_prod = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0;
          m_done = 1;
          m_prod = ref_mul(m_a, m_b, m_sgn);
          m_last_sgn = m_sgn;
        end
      end else if (start_i) begin
        m_busy = 1;
        m_rem  = N;
        m_a    = mult_a_i;
        m_b    = mult_b_i;
        m_sgn  = signed_i;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      chk(busy_o == m_busy, "R2/R7 busy", int'(busy_o), int'(m_busy));
      chk(done_o == m_done, "R3 done", int'(done_o), int'(m_done));
      if (!m_busy) begin
        if (m_done)
          chk(product_o == m_prod, ign_seen ? "R6 product" : (m_last_sgn ? "R5 product" : "R4 product"),
              int'(product_o), int'(m_prod));
        else
          chk(product_o == m_prod, "R8 hold", int'(product_o), int'(m_prod));
      end
    end
  end

  task automatic run_op(logic [N-1:0] a, logic [N-1:0] b, bit s);
    while (busy_o) @(negedge clk);
    start_i  = 1'b1;
    mult_a_i = a;
    mult_b_i = b;
    signed_i = s;
    @(negedge clk);
    start_i  = 1'b0;
    mult_a_i = ~a;
    mult_b_i = b ^ 4'h5;
    signed_i = ~s;
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mult_a_i = '0; mult_b_i = '0; signed_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reset flags", int'({busy_o, done_o}), 0);
    chk(product_o == '0, "R1 reset product", int'(product_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && product_o == '0, "R1 after release", int'(product_o), 0);
    running = 1;

    // exhaustive sweep: R4 unsigned, R5 signed (includes -8 * -8)
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          run_op(N'(a), N'(b), bit'(s));

    // explicit corner: most negative squared in signed mode (R5)
    run_op(4'h8, 4'h8, 1'b1);
    @(negedge clk);
    chk(product_o == 8'h40, "R5 min*min", int'(product_o), 'h40);

    // R6: inputs ignored while busy
    while (busy_o) @(negedge clk);
    start_i = 1'b1; mult_a_i = 4'hD; mult_b_i = 4'h6; signed_i = 1'b1;
    @(negedge clk);
    ign_seen = 1;
    mult_a_i = 4'h7; mult_b_i = 4'hF; signed_i = 1'b0;
    repeat (N - 1) @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk(product_o == 8'hEE, "R6 -3*6", int'(product_o), 'hEE);
    @(negedge clk);
    ign_seen = 0;

    // R8: idle hold with wandering operands
    for (int k = 0; k < 8; k++) begin
      mult_a_i = N'(k * 3); mult_b_i = N'(k * 5); signed_i = k[0];
      @(negedge clk);
    end
    chk(product_o == 8'hEE, "R8 held result", int'(product_o), 'hEE);

    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule